// File: doc/BRIEF.md
# Display RAM host access port

This block sits between a host processor bus and the on-chip display data RAM, which holds 8-bit words in pages of 96 columns. The host can drive it with a parallel bus using either an enable-plus-direction strobe pair or separate active-low read and write strobes. It can also use a write-only serial line. The port samples the strobes on the core clock and turns each host cycle into one event. Command bytes set a page register and a column pointer. Data writes go to the RAM at the current location, and data reads are served through a one-word latch. Control reads return a status byte.

After each data access, whether read or write, the column pointer steps forward by one. Once it has reached the last column, the next data access still uses that column and then leaves the pointer at zero. The latch makes the read path one access behind: a read returns the word fetched by the read before it. So the first read after moving the pointer is a dummy read. RAM access does not depend on what is on display at the time.

The controller has three states. `ST_RESET` runs a fixed-length start-up sequence. During it only control reads are served, and they report both busy and reset. When the count expires it passes to `ST_IDLE`. `ST_IDLE` accepts every event. A data read moves it to `ST_FETCH`, where the RAM word is loaded into the latch, and `ST_FETCH` always returns to `ST_IDLE` after one cycle. Events that arrive in `ST_FETCH` are dropped.

Top module: `dram_host_port`

## Requirements
- R1: After reset, page, column and read latch are 0. For RST_CYCLES cycles the port stays in its reset sequence. In that time a control read returns BUSY=1 and RES=1, and every other access is ignored. After the sequence a control read shows BUSY=0 and RES=0, provided the busy input is low.
- R2: A control read (dc=0, read) returns the byte {BUSY, ON, RES, 5'b00000}, MSB first. BUSY is the `exec_busy` input ORed with the reset sequence, and ON is the `disp_on` input.
- R3: Command writes (dc=0, write) decode the upper nibble of the byte as follows. 4'b1011 loads the page from bits 3:0. 4'b0001 loads column bits 6:4 from bits 2:0. 4'b0000 loads column bits 3:0 from bits 3:0. Any other command byte changes neither address.
- R4: The RAM word address is page*96 + column. Address settings stay in force across any number of data accesses.
- R5: A data write (dc=1, write) stores the byte at the current address and then advances the column by one. Command writes and control reads leave the column unchanged.
- R6: A data access made while the column is 95 uses column 95 and leaves the column at 0.
- R7: A data read (dc=1, read) returns the latch content from before the access. It then loads the latch with the RAM word at the current address and advances the column, so the first read after setting an address is a dummy read.
- R8: In mode 2'b00, a rising edge of `e_rdn` while `cs_n` is low starts an access. If `rw_wrn` is high it is a read, and if it is low it is a write.
- R9: In mode 2'b01, a falling edge of `rw_wrn` is a write and a falling edge of `e_rdn` is a read, each taken only while `cs_n` is low.
- R10: In mode 2'b10, `sdin` is shifted MSB first on rising edges of `sclk` while `cs_n` is low, and `dc` is sampled with the eighth bit. The byte acts only as a write. Raising `cs_n` discards a partial byte, and the parallel strobes are ignored in this mode.
- R11: Strobe edges seen while `cs_n` is high cause no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_mode | input | 2 | 00 enable/direction parallel, 01 split-strobe parallel, 10 serial, 11 no bus |
| cs_n | input | 1 | Active-low chip select |
| dc | input | 1 | 1 = data, 0 = command or status |
| rw_wrn | input | 1 | Direction (mode 00) or active-low write strobe (mode 01) |
| e_rdn | input | 1 | Enable (mode 00) or active-low read strobe (mode 01) |
| din | input | 8 | Parallel write byte |
| dout | output | 8 | Read byte, held until the next read |
| sclk | input | 1 | Serial shift clock |
| sdin | input | 1 | Serial data |
| disp_on | input | 1 | Display-on flag for the status byte |
| exec_busy | input | 1 | Busy flag from command execution |
| ram_addr | output | 11 | RAM word address |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_re | output | 1 | RAM read enable; data returns one cycle later |
| ram_rdata | input | 8 | RAM read data |

## Verification
A strobe edge is registered one clock after it is visible, and the state machine acts on it at the following edge. So `dout` and the RAM write both change on the second rising edge after the edge is presented, and the latch reload completes one edge later. The bench keeps a behavioural model that it updates just after that second edge. It compares `dout` to the model at every falling edge, so a result that is a cycle early or late shows up as a mismatch. RAM contents, wrap and ignored accesses are checked by reading the affected locations back through the dummy-read pipeline.

// File: rtl/dram_host_pkg.sv
package dram_host_pkg;

    typedef enum logic [1:0] {
        BUS_M68 = 2'b00,
        BUS_I80 = 2'b01,
        BUS_SER = 2'b10,
        BUS_OFF = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        ST_RESET = 2'b00,
        ST_IDLE  = 2'b01,
        ST_FETCH = 2'b10
    } port_state_e;

    typedef struct packed {
        logic       valid;
        logic       rd;
        logic       dc;
        logic [7:0] dat;
    } host_ev_t;

    localparam logic [3:0] CMD_PAGE   = 4'b1011;
    localparam logic [3:0] CMD_COL_HI = 4'b0001;
    localparam logic [3:0] CMD_COL_LO = 4'b0000;

endpackage

// File: rtl/host_strobe_decode.sv
module host_strobe_decode
    import dram_host_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       cs_n,
    input  logic       dc,
    input  logic       rw_wrn,
    input  logic       e_rdn,
    input  logic [7:0] din,
    input  logic       sclk,
    input  logic       sdin,
    output host_ev_t   ev
);

    logic       e_q;
    logic       w_q;
    logic       sclk_q;
    logic [6:0] shift_q;
    logic [2:0] bit_cnt;

    logic m68_hit;
    logic i80_wr;
    logic i80_rd;
    logic ser_hit;
    logic ser_done;

    always_comb begin
        m68_hit  = (mode == BUS_M68) && !cs_n && e_rdn && !e_q;
        i80_wr   = (mode == BUS_I80) && !cs_n && !rw_wrn && w_q;
        i80_rd   = (mode == BUS_I80) && !cs_n && !e_rdn && e_q;
        ser_hit  = (mode == BUS_SER) && !cs_n && sclk && !sclk_q;
        ser_done = ser_hit && (bit_cnt == 3'd7);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q    <= 1'b1;
            w_q    <= 1'b1;
            sclk_q <= 1'b1;
        end else begin
            e_q    <= e_rdn;
            w_q    <= rw_wrn;
            sclk_q <= sclk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            bit_cnt <= '0;
        end else if (cs_n || (mode != BUS_SER)) begin
            bit_cnt <= '0;
        end else if (ser_hit) begin
            shift_q <= {shift_q[5:0], sdin};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev <= '0;
        end else begin
            ev.valid <= m68_hit || i80_wr || i80_rd || ser_done;
            ev.rd    <= m68_hit ? rw_wrn : (!i80_wr && i80_rd);
            ev.dc    <= dc;
            ev.dat   <= ser_done ? {shift_q, sdin} : din;
        end
    end

    // R11: a deselected bus produces no event
    a_r11_cs_gates: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !ev.valid);

    // R10: a completed serial byte always becomes a write
    a_r10_serial_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        ser_done |=> (ev.valid && !ev.rd));

endmodule

// File: rtl/col_page_ptr.sv
module col_page_ptr
    import dram_host_pkg::*;
#(
    parameter int PAGES = 16,
    parameter int COLS  = 96
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_we,
    input  logic [7:0]                 cmd_byte,
    input  logic                       adv,
    output logic [$clog2(PAGES)-1:0]   page,
    output logic [$clog2(COLS)-1:0]    col
);

    localparam int PG_W  = $clog2(PAGES);
    localparam int COL_W = $clog2(COLS);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    logic [3:0] op;
    assign op = cmd_byte[7:4];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page <= '0;
            col  <= '0;
        end else if (cmd_we) begin
            unique case (op)
                CMD_PAGE:   page          <= cmd_byte[PG_W-1:0];
                CMD_COL_HI: col[COL_W-1:4] <= cmd_byte[COL_W-5:0];
                CMD_COL_LO: col[3:0]       <= cmd_byte[3:0];
                default:    ;
            endcase
        end else if (adv) begin
            col <= (col >= COL_LAST) ? '0 : col + COL_W'(1);
        end
    end

    // R6: the last column is used once, then the pointer restarts at zero
    a_r6_wrap_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !cmd_we && col == COL_LAST) |=> (col == '0));

    // R4: data accesses never move the page
    a_r4_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !cmd_we) |=> $stable(page));

    // R5: a page command leaves the column alone
    a_r5_page_cmd_col_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && op == CMD_PAGE) |=> $stable(col));

    // R3: unknown command bytes alter no address
    a_r3_unknown_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && op != CMD_PAGE && op != CMD_COL_HI && op != CMD_COL_LO)
        |=> ($stable(col) && $stable(page)));

endmodule

// File: rtl/dram_host_port.sv
module dram_host_port
    import dram_host_pkg::*;
#(
    parameter int PAGES      = 16,
    parameter int COLS       = 96,
    parameter int RST_CYCLES = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [1:0]                        bus_mode,
    input  logic                              cs_n,
    input  logic                              dc,
    input  logic                              rw_wrn,
    input  logic                              e_rdn,
    input  logic [7:0]                        din,
    output logic [7:0]                        dout,
    input  logic                              sclk,
    input  logic                              sdin,
    input  logic                              disp_on,
    input  logic                              exec_busy,
    output logic [$clog2(PAGES*COLS)-1:0]     ram_addr,
    output logic                              ram_we,
    output logic [7:0]                        ram_wdata,
    output logic                              ram_re,
    input  logic [7:0]                        ram_rdata
);

    localparam int PG_W   = $clog2(PAGES);
    localparam int COL_W  = $clog2(COLS);
    localparam int ADDR_W = $clog2(PAGES*COLS);
    localparam int RCNT_W = $clog2(RST_CYCLES + 1);

    host_ev_t           ev;
    logic [PG_W-1:0]    page;
    logic [COL_W-1:0]   col;

    port_state_e        state_q, state_d;
    logic [RCNT_W-1:0]  rst_cnt;
    logic [7:0]         rd_latch;
    logic [7:0]         dout_q;

    logic in_reset;
    logic accept;
    logic stat_rd;
    logic data_wr;
    logic data_rd;
    logic cmd_wr;
    logic [7:0] status;

    host_strobe_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (bus_mode),
        .cs_n   (cs_n),
        .dc     (dc),
        .rw_wrn (rw_wrn),
        .e_rdn  (e_rdn),
        .din    (din),
        .sclk   (sclk),
        .sdin   (sdin),
        .ev     (ev)
    );

    col_page_ptr #(.PAGES(PAGES), .COLS(COLS)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_wr),
        .cmd_byte (ev.dat),
        .adv      (data_wr || data_rd),
        .page     (page),
        .col      (col)
    );

    // event qualification and status assembly
    always_comb begin
        in_reset = (state_q == ST_RESET);
        accept   = ev.valid && (state_q == ST_IDLE);
        stat_rd  = ev.valid && ev.rd && !ev.dc && (state_q != ST_FETCH);
        data_wr  = accept && !ev.rd && ev.dc;
        data_rd  = accept && ev.rd && ev.dc;
        cmd_wr   = accept && !ev.rd && !ev.dc;
        status   = {exec_busy || in_reset, disp_on, in_reset, 5'b00000};
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: if (rst_cnt == RCNT_W'(RST_CYCLES - 1)) state_d = ST_IDLE;
            ST_IDLE:  if (data_rd) state_d = ST_FETCH;
            ST_FETCH: state_d = ST_IDLE;
            default:  state_d = ST_RESET;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            rst_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (in_reset) rst_cnt <= rst_cnt + RCNT_W'(1);
        end
    end

    // outputs: RAM port
    always_comb begin
        ram_addr  = ADDR_W'(page) * ADDR_W'(COLS) + ADDR_W'(col);
        ram_we    = data_wr;
        ram_wdata = ev.dat;
        ram_re    = data_rd;
    end

    // outputs: read latch and host data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_latch <= '0;
            dout_q   <= '0;
        end else begin
            if (state_q == ST_FETCH) rd_latch <= ram_rdata;
            if (stat_rd)             dout_q   <= status;
            else if (data_rd)        dout_q   <= rd_latch;
        end
    end

    assign dout = dout_q;

    // R7: a RAM read is followed by exactly one fetch cycle
    a_r7_fetch_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (state_q == ST_FETCH && !ram_re));

    // R7: the host sees the latch content from before the access
    a_r7_stale_to_host: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |=> (dout == $past(rd_latch)));

    // R1: no RAM traffic during the reset sequence
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_reset |-> (!ram_we && !ram_re));

    // R2: a status read during the reset sequence reports busy and reset
    a_r2_status_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && in_reset) |=> (dout[7] && dout[5] && dout[4:0] == 5'b0));

endmodule

// File: tb/dram_host_port_tb_top.sv
module dram_host_port_tb_top;
    import dram_host_pkg::*;

    localparam int PAGES = 16;
    localparam int COLS  = 96;
    localparam int RSTC  = 40;
    localparam int WORDS = PAGES * COLS;
    localparam int AW    = $clog2(WORDS);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] bus_mode = 2'b00;
    logic cs_n = 1'b1, dc = 1'b0, rw_wrn = 1'b1, e_rdn = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic sclk = 1'b0, sdin = 1'b0;
    logic disp_on = 1'b0, exec_busy = 1'b0;
    logic [AW-1:0] ram_addr;
    logic ram_we, ram_re;
    logic [7:0] ram_wdata;
    logic [7:0] ram_rdata = '0;

    always #10 clk = ~clk;

    dram_host_port #(.PAGES(PAGES), .COLS(COLS), .RST_CYCLES(RSTC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_mode(bus_mode), .cs_n(cs_n), .dc(dc),
        .rw_wrn(rw_wrn), .e_rdn(e_rdn), .din(din), .dout(dout),
        .sclk(sclk), .sdin(sdin), .disp_on(disp_on), .exec_busy(exec_busy),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_re(ram_re), .ram_rdata(ram_rdata)
    );

    // RAM with one cycle read latency
    logic [7:0] mem [WORDS];
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
    end

    // behavioural reference model
    int   exp_mem [WORDS];
    int   m_page = 0, m_col = 0, m_latch = 0;
    logic [7:0] exp_dout = '0;
    bit   exp_rst = 1'b1;
    int   n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit   run = 1'b0;

    task automatic model_apply(bit dcv, bit rd, logic [7:0] b);
        if (!dcv && rd) begin
            exp_dout = {exec_busy | exp_rst, disp_on, exp_rst, 5'b0};
        end else if (exp_rst) begin
            // ignored during the reset sequence
        end else if (!dcv) begin
            if (b[7:4] == 4'b1011) m_page = int'(b[3:0]);
            else if (b[7:4] == 4'b0001) m_col = (m_col % 16) + 16 * int'(b[2:0]);
            else if (b[7:4] == 4'b0000) m_col = (m_col / 16) * 16 + int'(b[3:0]);
        end else begin
            if (rd) begin
                exp_dout = 8'(m_latch);
                m_latch  = exp_mem[m_page * COLS + m_col];
            end else begin
                exp_mem[m_page * COLS + m_col] = int'(b);
            end
            m_col = (m_col >= COLS - 1) ? 0 : m_col + 1;
        end
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (run) begin
            n_cmp++;
            if (dout !== exp_dout) begin
                n_bad++;
                $display("FAIL %s: dout actual %02h expected %02h", cur_req, dout, exp_dout);
            end
        end
    end

    // parallel access in the current mode; sel=0 keeps the chip deselected
    task automatic par_access(bit dcv, bit rd, logic [7:0] b, bit sel = 1'b1);
        @(negedge clk);
        cs_n = !sel; dc = dcv; din = b;
        if (bus_mode == 2'b00) rw_wrn = rd;
        @(negedge clk);
        if (bus_mode == 2'b00) e_rdn = 1'b1;
        else if (rd) e_rdn = 1'b0;
        else rw_wrn = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        if (sel) model_apply(dcv, rd, b);
        @(negedge clk);
        e_rdn = (bus_mode == 2'b00) ? 1'b0 : 1'b1;
        rw_wrn = 1'b1; cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic ser_send(bit dcv, logic [7:0] b, int nbits = 8);
        @(negedge clk);
        cs_n = 1'b0;
        for (int i = 7; i > 7 - nbits; i--) begin
            sdin = b[i]; dc = dcv;
            @(negedge clk); sclk = 1'b1;
            @(negedge clk); sclk = 1'b0;
        end
        repeat (3) @(negedge clk);
        if (nbits == 8) model_apply(dcv, 1'b0, b);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_addr(int pg, int cl);
        par_access(1'b0, 1'b0, {4'b1011, 4'(pg)});
        par_access(1'b0, 1'b0, {4'b0001, 4'(cl / 16)});
        par_access(1'b0, 1'b0, {4'b0000, 4'(cl % 16)});
    endtask

    bit done = 1'b0;

    initial begin
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = 8'(i) ^ 8'h3C;
            exp_mem[i] = int'(8'(i) ^ 8'h3C);
        end
        repeat (3) @(negedge clk);
        run = 1'b1;
        check("R1", dout, 8'h00);
        rst_n = 1'b1;

        // R1 / R2: inside the reset sequence
        cur_req = "R1";
        par_access(1'b0, 1'b1, 8'h00);
        check("R1", dout, 8'hA0);
        par_access(1'b1, 1'b0, 8'h55);
        par_access(1'b0, 1'b0, 8'hB5);
        repeat (RSTC + 10) @(negedge clk);
        exp_rst = 1'b0;
        par_access(1'b0, 1'b1, 8'h00);
        check("R1", dout, 8'h00);

        // R7: dummy read, then word 0 (untouched by the ignored write)
        cur_req = "R7";
        par_access(1'b1, 1'b1, 8'h00);
        check("R7", dout, 8'h00);
        par_access(1'b1, 1'b1, 8'h00);
        check("R1", dout, 8'h3C);

        // R3 / R4 / R5 / R8: write at page 3 column 37, read back
        cur_req = "R4";
        set_addr(3, 37);
        par_access(1'b0, 1'b0, 8'h80);
        par_access(1'b1, 1'b0, 8'hA5);
        par_access(1'b0, 1'b1, 8'h00);
        par_access(1'b1, 1'b0, 8'h5A);
        set_addr(3, 37);
        par_access(1'b1, 1'b1, 8'h00);
        par_access(1'b1, 1'b1, 8'h00);
        check("R8", dout, 8'hA5);
        par_access(1'b1, 1'b1, 8'h00);
        check("R5", dout, 8'h5A);
        check("R4", mem[3 * COLS + 37], 8'hA5);

        // R6: wrap from the last column
        cur_req = "R6";
        set_addr(1, 95);
        par_access(1'b1, 1'b0, 8'h11);
        par_access(1'b1, 1'b0, 8'h22);
        check("R6", mem[1 * COLS + 95], 8'h11);
        check("R6", mem[1 * COLS], 8'h22);
        set_addr(1, 95);
        par_access(1'b1, 1'b1, 8'h00);
        par_access(1'b1, 1'b1, 8'h00);
        check("R6", dout, 8'h11);
        par_access(1'b1, 1'b1, 8'h00);
        check("R6", dout, 8'h22);

        // R2: status flags
        cur_req = "R2";
        disp_on = 1'b1; exec_busy = 1'b1;
        par_access(1'b0, 1'b1, 8'h00);
        check("R2", dout, 8'hC0);
        exec_busy = 1'b0;
        par_access(1'b0, 1'b1, 8'h00);
        check("R2", dout, 8'h40);

        // R9: split-strobe mode
        cur_req = "R9";
        @(negedge clk); bus_mode = 2'b01; e_rdn = 1'b1;
        repeat (2) @(negedge clk);
        set_addr(7, 10);
        par_access(1'b1, 1'b0, 8'hE7);
        set_addr(7, 10);
        par_access(1'b1, 1'b1, 8'h00);
        par_access(1'b1, 1'b1, 8'h00);
        check("R9", dout, 8'hE7);

        // R11: deselected strobes do nothing
        cur_req = "R11";
        set_addr(7, 20);
        par_access(1'b1, 1'b0, 8'h99, 1'b0);
        par_access(1'b1, 1'b1, 8'h00);
        par_access(1'b1, 1'b1, 8'h00);
        check("R11", dout, 8'(7 * COLS + 20) ^ 8'h3C);

        // R10: serial writes, partial frame, parallel strobe ignored
        cur_req = "R10";
        @(negedge clk); bus_mode = 2'b10;
        repeat (2) @(negedge clk);
        ser_send(1'b1, 8'hFF, 3);
        ser_send(1'b0, 8'hB2);
        ser_send(1'b0, 8'h13);
        ser_send(1'b0, 8'h02);
        ser_send(1'b1, 8'hC3);
        @(negedge clk); cs_n = 1'b0; dc = 1'b1; din = 8'h77;
        @(negedge clk); rw_wrn = 1'b0;
        @(negedge clk); e_rdn = 1'b0;
        repeat (3) @(negedge clk);
        rw_wrn = 1'b1; e_rdn = 1'b1; cs_n = 1'b1;
        ser_send(1'b1, 8'h3D);
        @(negedge clk); bus_mode = 2'b01;
        repeat (2) @(negedge clk);
        set_addr(2, 50);
        par_access(1'b1, 1'b1, 8'h00);
        par_access(1'b1, 1'b1, 8'h00);
        check("R10", dout, 8'hC3);
        par_access(1'b1, 1'b1, 8'h00);
        check("R10", dout, 8'h3D);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule